// File: doc/BRIEF.md
# Float/Integer Register Bit-Move Unit

This execution unit carries a floating-point bit pattern between the floating-point register side and the integer register side of a core. It takes a decoded instruction word and one 64-bit source operand. One clock later it returns the value to write, the index of the target register and a write enable for the correct register file.

Four operations are supported. Two of them copy all 64 bits unchanged, one in each direction. The other two are single-precision forms, and they are not plain copies. Moving toward the integer side narrows the 64-bit register image to the 32-bit storage image of a single, in the same way as a store-single. Moving toward the float side widens a 32-bit single image to the 64-bit register format, in the same way as a load-single.

Each operation also has a record form. In the record form, a move to the integer side produces an integer-style condition field. A move to the float side instead passes the floating-point summary bits into the second condition field. The unit never touches floating-point status.

Top module: `fpmv_unit`

## Requirements
- R1: The instruction word is numbered with bit 0 as its MSB (`insn[31]`). The fields are: primary opcode in bits 0-5 (default 22), target index in bits 6-10, a must-be-zero field in bits 11-15, source index in bits 16-20, extended opcode in bits 21-30 and the record flag in bit 31 (`insn[0]`). The default extended opcodes are 300 (64-bit to integer), 301 (single to integer), 302 (64-bit to float) and 303 (single to float). A wrong primary opcode, a nonzero must-be-zero field or any other extended opcode raises `out_illegal` and holds `gpr_we`, `fpr_we` and `cr_we` low.
- R2: The 64-bit to-integer move writes the source unchanged to the integer side (`gpr_we`=1).
- R3: The single to-integer move writes zeros to `result[63:32]`. It writes the single image of the source to `result[31:0]`. When the double exponent is above 896 or is all-ones, that image is the sign, exponent bit 10, exponent bits 6:0 and fraction bits 51:29, with lower fraction bits dropped.
- R4: For a double exponent E between 874 and 896, the single to-integer move yields a denormal single. Its exponent field is zero and its fraction is ({1, fraction[51:29]} >> (897-E)).
- R5: The 64-bit to-float move writes the source unchanged to the float side (`fpr_we`=1).
- R6: The single to-float move uses only `src_op[31:0]`. A normal single gets its exponent rebiased by 896 and its fraction placed in the top 23 of the 52 fraction bits. An all-ones exponent becomes 2047 with the fraction kept, and a signed zero stays a signed zero.
- R7: In the single to-float move, a denormal single is normalized. If its fraction has its highest set bit at position p, the double exponent is 874+p and the bits below that leading one are left-aligned in the fraction.
- R8: In the record form of a to-integer move, `cr_we`=1 and `cr_sel`=0. `cr_val` is {LT,GT,EQ,SO} (bit 3 down to bit 0), formed by comparing `result` as a signed value with zero, with SO taken from `so_in`.
- R9: In the record form of a to-float move, `cr_we`=1, `cr_sel`=1 and `cr_val` equals `fpscr_sum`.
- R10: With the record flag clear, `cr_we` stays 0. At most one of `gpr_we` and `fpr_we` is set.
- R11: Every accepted instruction produces `out_valid` exactly one cycle later, with `tgt_idx` equal to its target field. An idle input cycle produces an idle output cycle.
- R12: While `rst_n` is low, `out_valid`, `out_illegal`, `gpr_we`, `fpr_we` and `cr_we` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| insn | input | 32 | Instruction word |
| src_op | input | 64 | Source register value |
| so_in | input | 1 | Summary-overflow bit for the integer condition field |
| fpscr_sum | input | 4 | Float summary bits {FX,FEX,VX,OX} |
| out_valid | output | 1 | Result present |
| out_illegal | output | 1 | Instruction rejected |
| gpr_we | output | 1 | Write the integer register file |
| fpr_we | output | 1 | Write the float register file |
| tgt_idx | output | 5 | Target register index |
| result | output | 64 | Value to write |
| cr_we | output | 1 | Condition field write enable |
| cr_sel | output | 1 | 0: integer field, 1: float field |
| cr_val | output | 4 | Condition field value |

## Verification
The bench targets the points where a single-precision move stops being a bit copy. These are the smallest and largest single denormals in both directions, where a wrong shift count or rebias puts the value off by a power of two. It also covers infinity and NaN, where a design that rebiases the all-ones exponent corrupts the pattern, and fraction bits below the single width, which must be dropped rather than rounded. The record forms are driven with negative, zero and positive results and with `so_in` set, to catch a swapped condition field or a signed/unsigned compare. The bench also sends malformed words in which only the zero field or only the extended opcode is wrong, to catch decode that lets a write through.

// File: rtl/fpmv_pkg.sv
package fpmv_pkg;

  localparam int unsigned DW   = 64;
  localparam int unsigned SW   = 32;
  localparam int unsigned IW   = 32;
  localparam int unsigned RIW  = 5;
  localparam int unsigned XOW  = 10;
  localparam int unsigned POW  = 6;
  localparam int unsigned CRW  = 4;
  localparam int unsigned DEXP = 11;
  localparam int unsigned DFRC = 52;
  localparam int unsigned SEXP = 8;
  localparam int unsigned SFRC = 23;
  localparam int unsigned FPAD = DFRC - SFRC;

  localparam logic [DEXP-1:0] REBIAS     = 11'd896;
  localparam logic [DEXP-1:0] DENORM_LO  = 11'd874;
  localparam logic [DEXP-1:0] DENORM_TOP = 11'd897;

  typedef enum logic [2:0] {
    MV_NONE,
    MV_TO_INT64,
    MV_TO_INT32,
    MV_TO_FP64,
    MV_TO_FP32
  } mv_op_e;

  typedef struct packed {
    mv_op_e         op;
    logic           illegal;
    logic           rec;
    logic [RIW-1:0] tgt;
  } mv_dec_t;

  function automatic logic op_to_int(input mv_op_e op);
    return (op == MV_TO_INT64) || (op == MV_TO_INT32);
  endfunction

  function automatic logic op_to_fp(input mv_op_e op);
    return (op == MV_TO_FP64) || (op == MV_TO_FP32);
  endfunction

  // Highest set bit of a single fraction (0 when empty).
  function automatic logic [4:0] lead_one(input logic [SFRC-1:0] f);
    logic [4:0] p;
    p = '0;
    for (int i = 0; i < SFRC; i++) begin
      if (f[i]) p = i[4:0];
    end
    return p;
  endfunction

  // 32-bit storage image -> 64-bit register image.
  function automatic logic [DW-1:0] sp_widen(input logic [SW-1:0] s);
    logic            sg;
    logic [SEXP-1:0] e;
    logic [SFRC-1:0] f;
    logic [4:0]      p;
    logic [SFRC-1:0] fn;
    logic [DEXP-1:0] de;
    logic [DW-1:0]   r;
    sg = s[SW-1];
    e  = s[SW-2 -: SEXP];
    f  = s[SFRC-1:0];
    if (e == '1) begin
      r = {sg, {DEXP{1'b1}}, f, {FPAD{1'b0}}};
    end else if (e != '0) begin
      de = {3'b000, e} + REBIAS;
      r  = {sg, de, f, {FPAD{1'b0}}};
    end else if (f == '0) begin
      r = {sg, {(DW-1){1'b0}}};
    end else begin
      p  = lead_one(f);
      fn = f << (5'd23 - p);
      de = DENORM_LO + {6'd0, p};
      r  = {sg, de, fn, {FPAD{1'b0}}};
    end
    return r;
  endfunction

  // 64-bit register image -> 32-bit storage image.
  function automatic logic [SW-1:0] dp_narrow(input logic [DW-1:0] d);
    logic            sg;
    logic [DEXP-1:0] e;
    logic [SFRC:0]   m;
    logic [DEXP-1:0] sh;
    logic [SFRC:0]   fr;
    logic [SW-1:0]   r;
    sg = d[DW-1];
    e  = d[DW-2 -: DEXP];
    if ((e == '1) || (e > REBIAS)) begin
      r = {sg, e[DEXP-1], e[6:0], d[DFRC-1 -: SFRC]};
    end else if (e >= DENORM_LO) begin
      m  = {1'b1, d[DFRC-1 -: SFRC]};
      sh = DENORM_TOP - e;
      fr = m >> sh[4:0];
      r  = {sg, {SEXP{1'b0}}, fr[SFRC-1:0]};
    end else begin
      r = {sg, {(SW-1){1'b0}}};
    end
    return r;
  endfunction

  // Integer condition field {LT,GT,EQ,SO}.
  function automatic logic [CRW-1:0] int_cond(input logic [DW-1:0] v, input logic so);
    logic z;
    z = (v == '0);
    return {v[DW-1], !v[DW-1] && !z, z, so};
  endfunction

endpackage

// File: rtl/fpmv_decode.sv
module fpmv_decode
  import fpmv_pkg::*;
#(
  parameter logic [POW-1:0] PRIMARY = 6'd22,
  parameter logic [XOW-1:0] XO_I64  = 10'd300,
  parameter logic [XOW-1:0] XO_I32  = 10'd301,
  parameter logic [XOW-1:0] XO_F64  = 10'd302,
  parameter logic [XOW-1:0] XO_F32  = 10'd303
) (
  input  logic [IW-1:0] insn,
  output mv_dec_t       dec
);
  logic [POW-1:0] f_po;
  logic [RIW-1:0] f_zero;
  logic [XOW-1:0] f_xo;
  mv_op_e         op_raw;
  logic           bad_fmt;

  assign f_po   = insn[31:26];
  assign f_zero = insn[20:16];
  assign f_xo   = insn[10:1];

  always_comb begin
    unique case (f_xo)
      XO_I64:  op_raw = MV_TO_INT64;
      XO_I32:  op_raw = MV_TO_INT32;
      XO_F64:  op_raw = MV_TO_FP64;
      XO_F32:  op_raw = MV_TO_FP32;
      default: op_raw = MV_NONE;
    endcase
  end

  assign bad_fmt = (f_po != PRIMARY) || (f_zero != '0) || (op_raw == MV_NONE);

  always_comb begin
    dec.op      = bad_fmt ? MV_NONE : op_raw;
    dec.illegal = bad_fmt;
    dec.rec     = insn[0];
    dec.tgt     = insn[25:21];
  end

  always_comb begin
    if (!$isunknown(insn)) begin
      AST_DEC_CLEAN: assert (dec.illegal == (dec.op == MV_NONE)); // R1
    end
  end
endmodule

// File: rtl/fpmv_datapath.sv
module fpmv_datapath
  import fpmv_pkg::*;
(
  input  mv_op_e        op,
  input  logic [DW-1:0] src,
  output logic [DW-1:0] res
);
  logic [DW-1:0] widened;
  logic [SW-1:0] narrowed;

  assign widened  = sp_widen(src[SW-1:0]);
  assign narrowed = dp_narrow(src);

  always_comb begin
    unique case (op)
      MV_TO_INT64, MV_TO_FP64: res = src;
      MV_TO_INT32:             res = {{(DW-SW){1'b0}}, narrowed};
      MV_TO_FP32:              res = widened;
      default:                 res = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown(src) && op == MV_TO_FP32) begin
      AST_WIDEN_SIGN: assert (res[DW-1] == src[SW-1]); // R6
    end
  end
endmodule

// File: rtl/fpmv_crgen.sv
module fpmv_crgen
  import fpmv_pkg::*;
(
  input  mv_op_e         op,
  input  logic           rec,
  input  logic [DW-1:0]  res,
  input  logic           so_in,
  input  logic [CRW-1:0] fpscr_sum,
  output logic           we,
  output logic           sel,
  output logic [CRW-1:0] val
);
  logic to_i;
  logic to_f;

  assign to_i = op_to_int(op);
  assign to_f = op_to_fp(op);
  assign we   = rec && (to_i || to_f);
  assign sel  = to_f;
  assign val  = to_f ? fpscr_sum : int_cond(res, so_in);
endmodule

// File: rtl/fpmv_unit.sv
module fpmv_unit
  import fpmv_pkg::*;
#(
  parameter logic [POW-1:0] PRIMARY = 6'd22,
  parameter logic [XOW-1:0] XO_I64  = 10'd300,
  parameter logic [XOW-1:0] XO_I32  = 10'd301,
  parameter logic [XOW-1:0] XO_F64  = 10'd302,
  parameter logic [XOW-1:0] XO_F32  = 10'd303
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [31:0]    insn,
  input  logic [63:0]    src_op,
  input  logic           so_in,
  input  logic [3:0]     fpscr_sum,
  output logic           out_valid,
  output logic           out_illegal,
  output logic           gpr_we,
  output logic           fpr_we,
  output logic [4:0]     tgt_idx,
  output logic [63:0]    result,
  output logic           cr_we,
  output logic           cr_sel,
  output logic [3:0]     cr_val
);
  mv_dec_t        dec_c;
  logic [DW-1:0]  res_c;
  logic           crwe_c;
  logic           crsel_c;
  logic [CRW-1:0] crval_c;
  mv_op_e         op_q;

  fpmv_decode #(
    .PRIMARY(PRIMARY), .XO_I64(XO_I64), .XO_I32(XO_I32),
    .XO_F64(XO_F64), .XO_F32(XO_F32)
  ) u_dec (
    .insn (insn),
    .dec  (dec_c)
  );

  fpmv_datapath u_dp (
    .op  (dec_c.op),
    .src (src_op),
    .res (res_c)
  );

  fpmv_crgen u_cr (
    .op        (dec_c.op),
    .rec       (dec_c.rec),
    .res       (res_c),
    .so_in     (so_in),
    .fpscr_sum (fpscr_sum),
    .we        (crwe_c),
    .sel       (crsel_c),
    .val       (crval_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      gpr_we      <= 1'b0;
      fpr_we      <= 1'b0;
      cr_we       <= 1'b0;
      cr_sel      <= 1'b0;
      cr_val      <= '0;
      tgt_idx     <= '0;
      result      <= '0;
      op_q        <= MV_NONE;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid && dec_c.illegal;
      gpr_we      <= in_valid && op_to_int(dec_c.op);
      fpr_we      <= in_valid && op_to_fp(dec_c.op);
      cr_we       <= in_valid && crwe_c;
      if (in_valid) begin
        cr_sel  <= crsel_c;
        cr_val  <= crval_c;
        tgt_idx <= dec_c.tgt;
        result  <= res_c;
        op_q    <= dec_c.op;
      end
    end
  end

  AST_IN_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !gpr_we && !fpr_we && !cr_we); // R11
  AST_TGT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> tgt_idx == $past(insn[25:21])); // R11
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> !gpr_we && !fpr_we && !cr_we); // R1
  AST_ONE_FILE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gpr_we, fpr_we})); // R10
  AST_CR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> (gpr_we || fpr_we)); // R10
  AST_CR_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> (cr_sel == fpr_we)); // R9
  AST_CR0_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_we && !cr_sel) |-> (cr_val[3] == result[63]) && (cr_val[1] == (result == '0))); // R8
  AST_COPY64: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (dec_c.op == MV_TO_INT64 || dec_c.op == MV_TO_FP64)) |=> result == $past(src_op)); // R2
  AST_SINGLE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (gpr_we && op_q == MV_TO_INT32) |-> result[63:32] == '0); // R3
  AST_FP32_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_c.op == MV_TO_FP32 && $stable(src_op[31:0]) && $past(in_valid)
     && $past(dec_c.op) == MV_TO_FP32) |-> res_c == $past(res_c)); // R6
endmodule

// File: tb/tb_fpmv_unit.sv
module tb_fpmv_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] src_op = '0;
  logic        so_in = 1'b0;
  logic [3:0]  fpscr_sum = '0;
  logic        out_valid, out_illegal, gpr_we, fpr_we, cr_we, cr_sel;
  logic [4:0]  tgt_idx;
  logic [63:0] result;
  logic [3:0]  cr_val;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic        ill;
    logic        gwe;
    logic        fwe;
    logic [63:0] res;
    logic [4:0]  tgt;
    logic        cwe;
    logic        csel;
    logic [3:0]  cval;
    string       req;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  fpmv_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .src_op(src_op),
    .so_in(so_in), .fpscr_sum(fpscr_sum), .out_valid(out_valid), .out_illegal(out_illegal),
    .gpr_we(gpr_we), .fpr_we(fpr_we), .tgt_idx(tgt_idx), .result(result),
    .cr_we(cr_we), .cr_sel(cr_sel), .cr_val(cr_val)
  );

  localparam logic [5:0] PO  = 6'd22;
  localparam logic [9:0] XI64 = 10'd300, XI32 = 10'd301, XF64 = 10'd302, XF32 = 10'd303;

  function automatic logic [31:0] mk(input logic [5:0] po, input logic [4:0] rt,
                                     input logic [4:0] z, input logic [4:0] rb,
                                     input logic [9:0] xo, input logic rc);
    return {po, rt, z, rb, xo, rc};
  endfunction

  function automatic logic [3:0] cr0_of(input logic [63:0] v, input logic so);
    logic lt, gt, eq;
    lt = $signed(v) < 0;
    gt = $signed(v) > 0;
    eq = (v == 64'd0);
    return {lt, gt, eq, so};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic issue(input logic [31:0] ins, input logic [63:0] src, input logic so,
                       input logic [3:0] fs, input exp_t e);
    @(negedge clk);
    in_valid  = 1'b1;
    insn      = ins;
    src_op    = src;
    so_in     = so;
    fpscr_sum = fs;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      insn     = 32'hFFFF_FFFF;
    end
  endtask

  // Legal move: to_int selects file, rc selects record form.
  task automatic mv(input logic [9:0] xo, input logic [4:0] rt, input logic rc,
                    input logic [63:0] src, input logic [63:0] expres,
                    input logic so, input logic [3:0] fs, input string req);
    exp_t e;
    logic ti;
    ti     = (xo == XI64) || (xo == XI32);
    e.ill  = 1'b0;
    e.gwe  = ti;
    e.fwe  = !ti;
    e.res  = expres;
    e.tgt  = rt;
    e.cwe  = rc;
    e.csel = !ti;
    e.cval = ti ? cr0_of(expres, so) : fs;
    e.req  = req;
    issue(mk(PO, rt, 5'd0, 5'd9, xo, rc), src, so, fs, e);
  endtask

  task automatic bad(input logic [31:0] ins, input string req);
    exp_t e;
    e.ill = 1'b1; e.gwe = 1'b0; e.fwe = 1'b0; e.res = '0; e.tgt = ins[25:21];
    e.cwe = 1'b0; e.csel = 1'b0; e.cval = '0; e.req = req;
    issue(ins, 64'hDEAD_BEEF_0123_4567, 1'b1, 4'hF, e);
  endtask

  // Monitor: pops and compares whenever a result appears.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R11", "unexpected out_valid", 64'd1, 64'd0);
        end else begin
          e = sb.pop_front();
          chk(out_illegal == e.ill && gpr_we == e.gwe && fpr_we == e.fwe && cr_we == e.cwe
              && tgt_idx == e.tgt && (e.ill || result == e.res)
              && (!e.cwe || (cr_sel == e.csel && cr_val == e.cval)),
              e.req, "result", result, e.res);
          if (e.cwe && cr_val != e.cval)
            $display("  (%s cr_val actual=%h expected=%h)", e.req, cr_val, e.cval);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", sb.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(!out_valid && !out_illegal && !gpr_we && !fpr_we && !cr_we, "R12", "reset outputs",
        {59'd0, out_valid, out_illegal, gpr_we, fpr_we, cr_we}, 64'd0);
    rst_n = 1'b1;
    idle(1);

    // R2 / R5: plain copies, with and without record form
    mv(XI64, 5'd3,  1'b0, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 1'b0, 4'h0, "R2");
    mv(XF64, 5'd31, 1'b0, 64'hFEDC_BA98_7654_3210, 64'hFEDC_BA98_7654_3210, 1'b0, 4'h0, "R5");
    // R8: record to integer side: negative, zero, positive with SO set
    mv(XI64, 5'd4,  1'b1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 4'h0, "R8");
    mv(XI64, 5'd5,  1'b1, 64'h0, 64'h0, 1'b1, 4'h0, "R8");
    mv(XI32, 5'd6,  1'b1, 64'hBFF0_0000_0000_0000, 64'h0000_0000_BF80_0000, 1'b1, 4'h0, "R8");
    // R9: record to float side carries summary bits
    mv(XF64, 5'd7,  1'b1, 64'h1, 64'h1, 1'b1, 4'hA, "R9");
    mv(XF32, 5'd8,  1'b1, 64'h0000_0000_3F80_0000, 64'h3FF0_0000_0000_0000, 1'b0, 4'h5, "R9");
    idle(2);

    // R3: narrowing normals, truncation of low fraction bits
    mv(XI32, 5'd9,  1'b0, 64'h3FF0_0000_0000_0001, 64'h0000_0000_3F80_0000, 1'b0, 4'h0, "R3");
    mv(XI32, 5'd10, 1'b0, 64'hC004_0000_0000_0000, 64'h0000_0000_C020_0000, 1'b0, 4'h0, "R3");
    mv(XI32, 5'd11, 1'b0, 64'h7FF8_0000_2000_0000, 64'h0000_0000_7FC0_0001, 1'b0, 4'h0, "R3");
    mv(XI32, 5'd12, 1'b0, 64'hFFF0_0000_0000_0000, 64'h0000_0000_FF80_0000, 1'b0, 4'h0, "R3");
    // R4: narrowing into denormals (exponents 874, 875, 896)
    mv(XI32, 5'd13, 1'b0, 64'h36A0_0000_0000_0000, 64'h0000_0000_0000_0001, 1'b0, 4'h0, "R4");
    mv(XI32, 5'd14, 1'b0, 64'h36B8_0000_0000_0000, 64'h0000_0000_0000_0003, 1'b0, 4'h0, "R4");
    mv(XI32, 5'd15, 1'b0, 64'hB800_0000_0000_0000, 64'h0000_0000_8040_0000, 1'b0, 4'h0, "R4");
    idle(1);

    // R6: widening normals, specials, signed zero; upper source half ignored
    mv(XF32, 5'd16, 1'b0, 64'hFFFF_FFFF_C020_0000, 64'hC004_0000_0000_0000, 1'b0, 4'h0, "R6");
    mv(XF32, 5'd17, 1'b0, 64'h1234_5678_7F80_0000, 64'h7FF0_0000_0000_0000, 1'b0, 4'h0, "R6");
    mv(XF32, 5'd18, 1'b0, 64'h0000_0000_7FC0_0001, 64'h7FF8_0000_2000_0000, 1'b0, 4'h0, "R6");
    mv(XF32, 5'd19, 1'b0, 64'hAAAA_AAAA_8000_0000, 64'h8000_0000_0000_0000, 1'b0, 4'h0, "R6");
    // R7: widening denormals (smallest, two-bit, largest leading position)
    mv(XF32, 5'd20, 1'b0, 64'h0000_0000_0000_0001, 64'h36A0_0000_0000_0000, 1'b0, 4'h0, "R7");
    mv(XF32, 5'd21, 1'b0, 64'h0000_0000_0000_0003, 64'h36B8_0000_0000_0000, 1'b0, 4'h0, "R7");
    mv(XF32, 5'd22, 1'b0, 64'h0000_0000_8060_0000, 64'hB800_0000_0000_0000 | 64'h0008_0000_0000_0000, 1'b0, 4'h0, "R7");
    idle(1);

    // R1: malformed encodings, record flag set to tempt a CR write
    bad(mk(PO, 5'd1, 5'd4, 5'd2, XI64, 1'b1), "R1");
    bad(mk(PO, 5'd2, 5'd0, 5'd2, 10'd304, 1'b1), "R1");
    bad(mk(6'd23, 5'd3, 5'd0, 5'd2, XF32, 1'b0), "R1");
    // R10: legal move right after, record clear
    mv(XF64, 5'd0, 1'b0, 64'h5555_0000_AAAA_0000, 64'h5555_0000_AAAA_0000, 1'b1, 4'hF, "R10");
    idle(4);

    chk(sb.size() == 0, "R11", "scoreboard drained", sb.size(), 64'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule